// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the shift clock of a synchronous serial port master from the system clock. Two dividers are cascaded. The first is an even-only prescaler. The second is a programmable post-divider. The resulting bit period is `prescale * (1 + rate)` system clock cycles. Each serial clock period is made of two equal half-periods. Each half-period lasts `(1 + rate)` prescaler ticks, and one tick occurs every `prescale / 2` system cycles.

Both divider settings are written through one small configuration port. A select bit chooses the prescale setting or the rate setting. Writes are accepted only while the port is disabled. While the port is disabled, every counter is cleared and the serial clock rests at the idle level chosen by the polarity input. A shift engine next to the block uses the one-cycle rising-edge and falling-edge strobes to sample and launch data. It does not need to detect edges on the clock level itself.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset with the port disabled and polarity 0, `sclk_o` is 0, both strobes are 0, and both configuration read ports return 0.
- R2: The prescale read port always returns the written value with bit 0 forced to 0. A written value of 3 reads back as 2, and 255 reads back as 254.
- R3: A configuration write (`cfg_sel_i` = 0 for prescale, 1 for rate) is accepted only while `en_i` is 0. A write while `en_i` is 1 changes neither read port nor the clock timing.
- R4: While `en_i` is 0, `sclk_o` follows `cpol_i` one cycle later: it is 0 for polarity 0 and 1 for polarity 1. Both strobes stay 0.
- R5: Let P be the stored even prescale and R the rate. After `en_i` rises, the first serial clock edge appears on the outputs in the cycle after the P/2*(1+R)-th enabled clock edge. Every later half-period lasts P/2*(1+R) cycles.
- R6: A full serial clock period, from one rising edge to the next, lasts P*(1+R) system cycles.
- R7: A stored prescale of 0 (written as 0 or 1) divides exactly as a prescale of 2.
- R8: `rise_o` is high for exactly the one cycle in which `sclk_o` has just gone from 0 to 1. `fall_o` is high for exactly the one cycle in which `sclk_o` has just gone from 1 to 0. The two strobes are never high together.
- R9: Lowering `en_i` in the middle of a half-period clears both counters. On the next enable, the first edge again arrives after the full delay given in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; 0 clears the counters and parks the clock |
| cpol_i | input | 1 | Idle level of the serial clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Write target: 0 prescale, 1 rate |
| cfg_wdata_i | input | 8 | Configuration write data |
| psc_rd_o | output | 8 | Stored prescale, bit 0 always 0 |
| rate_rd_o | output | 8 | Stored rate value |
| sclk_o | output | 1 | Serial clock level |
| rise_o | output | 1 | One-cycle strobe on a rising edge of `sclk_o` |
| fall_o | output | 1 | One-cycle strobe on a falling edge of `sclk_o` |

## Verification
A configuration write shows on the read ports one cycle after the write edge. A change of polarity while the port is disabled also shows on `sclk_o` one cycle later. A clock edge and its strobe are registered together. Both therefore appear one cycle after the enabled edge at which the final post-divider tick lands, which is edge P/2*(1+R) counted from the first edge with `en_i` high. The bench drives its inputs and samples the outputs on the falling clock edge, and counts one falling edge for every rising edge. The counts it compares against P/2*(1+R) therefore match the delays of R5 and R6 exactly.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int unsigned CFG_W = 8;
  typedef enum logic {
    SEL_PSC  = 1'b0,
    SEL_RATE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs #(
  parameter int unsigned W = 8,
  localparam int unsigned HW = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [W-1:0]  wdata_i,
  output logic [HW-1:0] half_div_o,
  output logic [W-1:0]  rate_o,
  output logic [W-1:0]  psc_rd_o
);
  import sclk_gen_pkg::*;

  logic [HW-1:0] psc_hi_q, psc_hi_d;
  logic [W-1:0]  rate_q, rate_d;
  logic          wr_ok;

  assign wr_ok = we_i && !en_i;

  always_comb begin
    psc_hi_d = psc_hi_q;
    rate_d   = rate_q;
    if (wr_ok) begin
      if (cfg_sel_e'(sel_i) == SEL_PSC) psc_hi_d = wdata_i[W-1:1];
      else                              rate_d   = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_hi_q <= '0;
      rate_q   <= '0;
    end else if (wr_ok) begin
      psc_hi_q <= psc_hi_d;
      rate_q   <= rate_d;
    end
  end

  // the stored upper bits are prescale/2; a stored zero acts as prescale 2
  assign half_div_o = (psc_hi_q == '0) ? HW'(1) : psc_hi_q;
  assign rate_o     = rate_q;
  assign psc_rd_o   = {psc_hi_q, 1'b0};

  // R3: settings stay frozen while the port runs
  a_r3_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(psc_rd_o) && $stable(rate_o)));
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int unsigned W = 8,
  localparam int unsigned HW = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [HW-1:0] half_div_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == half_div_i - HW'(1));
  assign tick_o = en_i && wrap;

  always_comb begin
    if (!en_i || wrap) cnt_d = '0;
    else               cnt_d = cnt_q + HW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: the prescale count never passes its divisor
  a_r5_psc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < half_div_i));
  // R9: a disabled cycle leaves the counter cleared
  a_r9_psc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/sclk_postdiv.sv
module sclk_postdiv #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] rate_i,
  output logic         toggle_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         last;

  assign last     = (cnt_q == rate_i);
  assign toggle_o = tick_i && last;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_i) cnt_d = last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: the rate count stays within 0..rate
  a_r5_rate_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= rate_i));
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen #(
  parameter int unsigned W = sclk_gen_pkg::CFG_W,
  localparam int unsigned HW = W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cpol_i,
  input  logic         cfg_we_i,
  input  logic         cfg_sel_i,
  input  logic [W-1:0] cfg_wdata_i,
  output logic [W-1:0] psc_rd_o,
  output logic [W-1:0] rate_rd_o,
  output logic         sclk_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic [HW-1:0] half_div;
  logic [W-1:0]  rate;
  logic          tick, toggle;
  logic          sclk_q, sclk_d, rise_q, rise_d, fall_q, fall_d;

  sclk_cfg_regs #(.W(W)) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(cfg_we_i),
    .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i), .half_div_o(half_div),
    .rate_o(rate), .psc_rd_o(psc_rd_o)
  );

  sclk_prescaler #(.W(W)) i_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .half_div_i(half_div), .tick_o(tick)
  );

  sclk_postdiv #(.W(W)) i_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .rate_i(rate), .toggle_o(toggle)
  );

  always_comb begin
    if (en_i) begin
      sclk_d = sclk_q ^ toggle;
      rise_d = toggle && !sclk_q;
      fall_d = toggle && sclk_q;
    end else begin
      sclk_d = cpol_i;
      rise_d = 1'b0;
      fall_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign rate_rd_o = rate;

  // R8: strobes match the level change they announce
  a_r8_rise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sclk_o && !$past(sclk_o)));
  a_r8_fall_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!sclk_o && $past(sclk_o)));
  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  // R4: disabled port parks the clock at the polarity level
  a_r4_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ((sclk_o == $past(cpol_i)) && !rise_o && !fall_o));
endmodule

// File: tb/test_sclk_rate_gen.sv
module test_sclk_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  typedef struct packed {
    logic [7:0]  psc;
    logic [7:0]  rate;
    logic [15:0] half;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd2,   8'd0, 16'd1},
    '{8'd3,   8'd0, 16'd1},
    '{8'd4,   8'd2, 16'd6},
    '{8'd0,   8'd1, 16'd2},
    '{8'd10,  8'd3, 16'd20},
    '{8'd255, 8'd0, 16'd127},
    '{8'd6,   8'd4, 16'd15},
    '{8'd1,   8'd2, 16'd3}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_sel_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] psc_rd_o, rate_rd_o;
  logic       sclk_o, rise_o, fall_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  sclk_rate_gen i_sclk_rate_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .psc_rd_o(psc_rd_o), .rate_rd_o(rate_rd_o),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_LIMIT) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG_LIMIT);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // counts falling edges until the chosen strobe is seen
  task automatic count_until(input bit want_rise, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!(want_rise ? rise_o : fall_o) && n < 2000);
  endtask

  initial begin
    int n;
    int hl;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 sclk", sclk_o, 0);
    chk("R1 strobes", rise_o | fall_o, 0);
    chk("R1 psc_rd", psc_rd_o, 0);
    chk("R1 rate_rd", rate_rd_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, VECS[i].psc);
      cfg_write(1'b1, VECS[i].rate);
      chk("R2 psc lsb", psc_rd_o, int'(VECS[i].psc & 8'hFE));
      chk("R3 rate store", rate_rd_o, int'(VECS[i].rate));
      en_i = 1'b1;
      count_until(1'b1, n);
      chk("R5 first edge", n, int'(VECS[i].half));
      chk("R8 level at rise", sclk_o, 1);
      count_until(1'b0, n);
      chk("R5 half period", n, int'(VECS[i].half));
      hl = n;
      count_until(1'b1, n);
      chk("R6 full period", hl + n, 2 * int'(VECS[i].half));
      en_i = 1'b0;
      @(negedge clk_i);
    end

    // R7: prescale 0 behaves as 2, rate 4 gives half of 5 cycles
    cfg_write(1'b0, 8'd0);
    cfg_write(1'b1, 8'd4);
    en_i = 1'b1;
    count_until(1'b1, n);
    chk("R7 zero prescale", n, 5);
    en_i = 1'b0;

    // R4: idle high for polarity 1, first edge is a fall
    cpol_i = 1'b1;
    cfg_write(1'b0, 8'd4);
    cfg_write(1'b1, 8'd0);
    chk("R4 idle high", sclk_o, 1);
    en_i = 1'b1;
    count_until(1'b0, n);
    chk("R4 first fall", n, 2);
    chk("R4 level after fall", sclk_o, 0);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R4 back to idle", sclk_o, 1);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk("R4 idle low", sclk_o, 0);

    // R3: writes while enabled are dropped
    cfg_write(1'b0, 8'd4);
    cfg_write(1'b1, 8'd2);
    en_i = 1'b1;
    cfg_write(1'b0, 8'd40);
    cfg_write(1'b1, 8'd9);
    chk("R3 psc held", psc_rd_o, 4);
    chk("R3 rate held", rate_rd_o, 2);
    count_until(1'b1, n);
    chk("R3 timing held", n, 2);
    count_until(1'b0, n);
    chk("R3 half held", n, 6);

    // R8: strobe lasts one cycle
    count_until(1'b1, n);
    @(negedge clk_i);
    chk("R8 rise width", rise_o, 0);
    chk("R8 level held", sclk_o, 1);

    // R9: disable mid-half clears counters
    en_i = 1'b0;
    @(negedge clk_i);
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    en_i = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      n += int'(rise_o) + int'(fall_o);
    end
    chk("R9 quiet while off", n, 0);
    chk("R9 idle level", sclk_o, 0);
    en_i = 1'b1;
    count_until(1'b1, n);
    chk("R9 restart delay", n, 6);
    en_i = 1'b0;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule